// File: doc/BRIEF.md
# General-Purpose I/O Bank with Per-Pin Masked Writes

This block is one bank of general-purpose pins placed behind a plain 32-bit register bus. The bus has an address, a write strobe, write data and registered read data. The bank keeps three registers of its own. The first holds the output value of every pin. The second marks each pin as an input or an output. The third is an output-enable mask. The pad side is split into three 32-bit vectors: the level coming in, the value driven out, and the per-pin drive enable. A pin drives only when its direction bit and its enable bit are both set.

Software often needs to change one or a few pins without first reading the output register back. Two write-only half-word ports serve this purpose. One covers the low sixteen pins and one covers the high sixteen. Each write to them carries a sixteen-bit mask in its upper half and sixteen data bits in its lower half. A pin takes the new data only where its mask bit is clear, so a single store is enough to update a pin.

Input levels pass through a two-stage synchronizer before they can be read. The bank index sets where the registers sit in the address space. The pin count (22 or 32) sets which bits exist. Bits above the pin count read as zero and ignore writes.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and after it is released, the output, direction and enable registers are all zero. As a result `pin_out` and `pin_oe` are zero and every pin is an input.
- R2: A write to the low masked port (byte address 8×BANK) loads pin i (i = 0..15) from write-data bit i wherever mask bit 16+i is 0. The change shows on `pin_out` after the clock edge that takes the write.
- R3: A write to the high masked port (byte address 8×BANK+4) loads pin 16+i from write-data bit i wherever mask bit 16+i is 0.
- R4: On either masked port, a pin whose mask bit is 1 keeps its stored output value. Pins of the other half are never touched.
- R5: Reading either masked port returns 0.
- R6: The direction register (byte address 0x204+0x40×BANK) can be read and written. Bit value 1 marks an output.
- R7: The output-enable register (byte address 0x208+0x40×BANK) can be read and written.
- R8: `pin_oe` bit i is 1 exactly when direction bit i and enable bit i are both 1. `pin_out` always carries the stored output register.
- R9: The level register (byte address 0x40+4×BANK) returns the input pin levels, with 1 meaning high. A change on `pin_in` first appears in `bus_rdata` three rising edges after it is applied, and not after two.
- R10: Bits at or above PIN_COUNT read as 0 from every register. Writes to them are ignored, and they never drive `pin_out` or `pin_oe`.
- R11: Writes to any address the bank does not decode have no effect on its state. Reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address sampled at the previous edge |
| pin_in | input | 32 | Levels arriving from the pads |
| pin_out | output | 32 | Values sent to the pads |
| pin_oe | output | 32 | Per-pin pad drive enable |

## Verification
A register write takes effect on the rising edge that samples it. The bench therefore checks `pin_out` and `pin_oe` at the falling edge right after the write strobe is dropped. Read data is registered from the address, so every read holds the address for one edge and samples `bus_rdata` at the following falling edge. Input levels pass two synchronizer flops and then the read register. The bench keeps pins steady for three edges before any level read, and one directed case checks that the old value is still present after two edges and that the new value appears after three.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_LO,
        SEL_MASK_HI,
        SEL_LEVEL,
        SEL_DIR,
        SEL_OEN
    } gpb_sel_e;

    function automatic logic [DATA_W-1:0] live_bits(input int count);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < count);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] A_LO    = '0,
    parameter logic [ADDR_W-1:0] A_HI    = '0,
    parameter logic [ADDR_W-1:0] A_LEVEL = '0,
    parameter logic [ADDR_W-1:0] A_DIR   = '0,
    parameter logic [ADDR_W-1:0] A_OEN   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output gpb_sel_e          sel
);

    always_comb begin
        if (addr == A_LO) begin
            sel = SEL_MASK_LO;
        end else if (addr == A_HI) begin
            sel = SEL_MASK_HI;
        end else if (addr == A_LEVEL) begin
            sel = SEL_LEVEL;
        end else if (addr == A_DIR) begin
            sel = SEL_DIR;
        end else if (addr == A_OEN) begin
            sel = SEL_OEN;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter logic [DATA_W-1:0] LIVE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  gpb_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] oen_q
);

    logic [HALF_W-1:0] keep_n;
    logic [DATA_W-1:0] upd_en;
    logic [DATA_W-1:0] upd_val;
    logic [DATA_W-1:0] out_next;

    assign keep_n = ~wdata[DATA_W-1:HALF_W];

    always_comb begin
        upd_en  = '0;
        upd_val = '0;
        unique case (sel)
            SEL_MASK_LO: begin
                upd_en  = {{HALF_W{1'b0}}, keep_n};
                upd_val = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
            end
            SEL_MASK_HI: begin
                upd_en  = {keep_n, {HALF_W{1'b0}}};
                upd_val = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
            end
            default: begin
                upd_en  = '0;
                upd_val = '0;
            end
        endcase
        out_next = ((out_q & ~upd_en) | (upd_val & upd_en)) & LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            oen_q <= '0;
        end else if (we) begin
            out_q <= out_next;
            if (sel == SEL_DIR) dir_q <= wdata & LIVE;
            if (sel == SEL_OEN) oen_q <= wdata & LIVE;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BANK      = 0,
    parameter int PIN_COUNT = 32,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe
);

    localparam logic [DATA_W-1:0] LIVE    = live_bits(PIN_COUNT);
    localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(8 * BANK);
    localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(8 * BANK + 4);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(32'h040 + 4 * BANK);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(32'h204 + 32'h40 * BANK);
    localparam logic [ADDR_W-1:0] A_OEN   = ADDR_W'(32'h208 + 32'h40 * BANK);

    gpb_sel_e          sel;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] oen_q;
    logic [DATA_W-1:0] level;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    gpb_decode #(
        .ADDR_W (ADDR_W),
        .A_LO   (A_LO),
        .A_HI   (A_HI),
        .A_LEVEL(A_LEVEL),
        .A_DIR  (A_DIR),
        .A_OEN  (A_OEN)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    gpb_regs #(
        .LIVE(LIVE)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bus_we),
        .sel  (sel),
        .wdata(bus_wdata),
        .out_q(out_q),
        .dir_q(dir_q),
        .oen_q(oen_q)
    );

    gpb_sync #(
        .WIDTH (DATA_W),
        .STAGES(SYNC_LEN)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (level)
    );

    always_comb begin
        unique case (sel)
            SEL_LEVEL: rd_next = level & LIVE;
            SEL_DIR:   rd_next = dir_q;
            SEL_OEN:   rd_next = oen_q;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q & oen_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BANK      = 0,
    parameter int PIN_COUNT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] dir_q,
    input logic [DATA_W-1:0] oen_q
);

    localparam logic [DATA_W-1:0] LIVE  = live_bits(PIN_COUNT);
    localparam logic [ADDR_W-1:0] C_LO  = ADDR_W'(8 * BANK);
    localparam logic [ADDR_W-1:0] C_HI  = ADDR_W'(8 * BANK + 4);
    localparam logic [ADDR_W-1:0] C_DIR = ADDR_W'(32'h204 + 32'h40 * BANK);
    localparam logic [ADDR_W-1:0] C_OEN = ADDR_W'(32'h208 + 32'h40 * BANK);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0));

    // R2
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_LO) |=>
        (((pin_out[HALF_W-1:0] ^ $past(bus_wdata[HALF_W-1:0]))
          & ~$past(bus_wdata[DATA_W-1:HALF_W]) & LIVE[HALF_W-1:0]) == '0));

    // R3
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_HI) |=>
        (((pin_out[DATA_W-1:HALF_W] ^ $past(bus_wdata[HALF_W-1:0]))
          & ~$past(bus_wdata[DATA_W-1:HALF_W]) & LIVE[DATA_W-1:HALF_W]) == '0));

    // R4
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_LO) |=>
        (((pin_out[HALF_W-1:0] ^ $past(pin_out[HALF_W-1:0]))
          & $past(bus_wdata[DATA_W-1:HALF_W])) == '0)
        && $stable(pin_out[DATA_W-1:HALF_W]));

    // R4
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_HI) |=>
        (((pin_out[DATA_W-1:HALF_W] ^ $past(pin_out[DATA_W-1:HALF_W]))
          & $past(bus_wdata[DATA_W-1:HALF_W])) == '0)
        && $stable(pin_out[HALF_W-1:0]));

    // R5
    mask_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == C_LO || bus_addr == C_HI) |=> (bus_rdata == '0));

    // R6
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_DIR) |=> (dir_q == ($past(bus_wdata) & LIVE)));

    // R7
    oen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == C_OEN) |=> (oen_q == ($past(bus_wdata) & LIVE)));

    // R10
    dead_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out | pin_oe | bus_rdata) & ~LIVE) == '0);

endmodule

bind gpio_bank gpio_bank_chk #(
    .ADDR_W   (ADDR_W),
    .BANK     (BANK),
    .PIN_COUNT(PIN_COUNT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .dir_q    (dir_q),
    .oen_q    (oen_q)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] pin_in;
    logic [31:0] rdata0, rdata1;
    logic [31:0] pout0, pout1, poe0, poe1;

    int vectors  = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] m_out [2];
    logic [31:0] m_dir [2];
    logic [31:0] m_oen [2];

    always #2.5 clk = ~clk;

    gpio_bank #(.BANK(0), .PIN_COUNT(32)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pin_in(pin_in),
        .pin_out(pout0), .pin_oe(poe0)
    );

    gpio_bank #(.BANK(1), .PIN_COUNT(22)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pin_in(pin_in),
        .pin_out(pout1), .pin_oe(poe1)
    );

    function automatic logic [31:0] live(input int b);
        return (b == 0) ? 32'hFFFF_FFFF : 32'h003F_FFFF;
    endfunction

    function automatic logic [11:0] a_lo(input int b);  return 12'(8 * b);          endfunction
    function automatic logic [11:0] a_hi(input int b);  return 12'(8 * b + 4);      endfunction
    function automatic logic [11:0] a_lvl(input int b); return 12'(32'h40 + 4 * b); endfunction
    function automatic logic [11:0] a_dir(input int b); return 12'(32'h204 + 32'h40 * b); endfunction
    function automatic logic [11:0] a_oen(input int b); return 12'(32'h208 + 32'h40 * b); endfunction

    function automatic bit mapped(input logic [11:0] a);
        for (int b = 0; b < 2; b++) begin
            if (a == a_lo(b) || a == a_hi(b) || a == a_lvl(b) ||
                a == a_dir(b) || a == a_oen(b)) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] w,
                                          input bit upper);
        logic [31:0] r = old;
        for (int i = 0; i < 16; i++) begin
            if (!w[16 + i]) r[upper ? i + 16 : i] = w[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] expect_read(input int b, input logic [11:0] a);
        if (a == a_lvl(b)) return pin_in & live(b);
        if (a == a_dir(b)) return m_dir[b];
        if (a == a_oen(b)) return m_oen[b];
        return 32'h0;
    endfunction

    function automatic string req_of(input int b, input logic [11:0] a);
        if (a == a_lo(b) || a == a_hi(b)) return "R5";
        if (a == a_lvl(b)) return "R9";
        if (a == a_dir(b)) return "R6";
        if (a == a_oen(b)) return "R7";
        return "R11";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic check_pins(input string req);
        check(req, "pin_out bank0", pout0, m_out[0]);
        check(req, "pin_out bank1", pout1, m_out[1]);
        check("R8", "pin_oe bank0", poe0, m_dir[0] & m_oen[0]);
        check("R8", "pin_oe bank1", poe1, m_dir[1] & m_oen[1]);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        for (int b = 0; b < 2; b++) begin
            if (a == a_lo(b)) m_out[b] = merge(m_out[b], d, 1'b0) & live(b);
            if (a == a_hi(b)) m_out[b] = merge(m_out[b], d, 1'b1) & live(b);
            if (a == a_dir(b)) m_dir[b] = d & live(b);
            if (a == a_oen(b)) m_oen[b] = d & live(b);
        end
        check_pins(req);
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        @(negedge clk);
        check(req_of(0, a), "read bank0", rdata0, expect_read(0, a));
        check(req_of(1, a), "read bank1", rdata1, expect_read(1, a));
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1..run watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] ra;
        logic [31:0] old_pins;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
        for (int b = 0; b < 2; b++) begin
            m_out[b] = '0; m_dir[b] = '0; m_oen[b] = '0;
        end
        repeat (4) @(negedge clk);
        check("R1", "pin_out during reset", pout0 | pout1, 32'h0);
        check("R1", "pin_oe during reset", poe0 | poe1, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R1");
        bus_read(a_dir(0));
        bus_read(a_oen(1));

        // R2 and R4: only pins 0-7 change, the rest keep their value
        bus_write(a_lo(0), 32'hFF00_00FF, "R2");
        bus_write(a_lo(0), 32'h00FF_0000, "R4");
        // R3: full upper half on bank0
        bus_write(a_hi(0), 32'h0000_A5A5, "R3");
        bus_write(a_hi(0), 32'hFFFE_0000, "R4");
        // R10: narrow bank drops bits 22 and above
        bus_write(a_hi(1), 32'h0000_FFFF, "R10");
        bus_write(a_dir(1), 32'hFFFF_FFFF, "R10");
        bus_write(a_oen(1), 32'hF0F0_F0F0, "R10");
        bus_read(a_dir(1));
        bus_read(a_oen(1));
        // R8: enable without direction does not drive
        bus_write(a_oen(0), 32'h0000_FFFF, "R8");
        bus_write(a_dir(0), 32'h00FF_00FF, "R8");
        // R5
        bus_read(a_lo(0));
        bus_read(a_hi(1));
        // R11: stray address
        bus_write(12'h3F0, 32'hFFFF_FFFF, "R11");
        bus_read(12'h3F0);

        // R9: latency of the level path, address held on the level register
        set_pins(32'h1234_5678);
        old_pins = pin_in;
        @(negedge clk);
        bus_addr = a_lvl(0);
        pin_in   = 32'hCAFE_F00D;
        @(negedge clk);
        @(negedge clk);
        check("R9", "level after two edges", rdata0, old_pins);
        @(negedge clk);
        check("R9", "level after three edges", rdata0, 32'hCAFE_F00D);
        bus_read(a_lvl(1));

        for (int n = 0; n < 400; n++) begin
            int b;
            int op;
            b  = int'($urandom_range(0, 1));
            op = int'($urandom_range(0, 7));
            case (op)
                0: bus_write(a_lo(b), $urandom, "R2");
                1: bus_write(a_hi(b), $urandom, "R3");
                2: bus_write(a_dir(b), $urandom, "R6");
                3: bus_write(a_oen(b), $urandom, "R7");
                4: begin
                    ra = 12'($urandom_range(0, 4095));
                    while (mapped(ra)) ra = 12'($urandom_range(0, 4095));
                    bus_write(ra, $urandom, "R11");
                end
                5: set_pins($urandom);
                default: begin
                    case ($urandom_range(0, 5))
                        0: bus_read(a_lo(b));
                        1: bus_read(a_hi(b));
                        2: bus_read(a_lvl(b));
                        3: bus_read(a_dir(b));
                        4: bus_read(a_oen(b));
                        default: begin
                            ra = 12'($urandom_range(0, 4095));
                            while (mapped(ra)) ra = 12'($urandom_range(0, 4095));
                            bus_read(ra);
                        end
                    endcase
                end
            endcase
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule